// File: doc/BRIEF.md
# Single-Wire Frame Multiplexing Transmitter

This block packs three things onto a single serial output: a frame-rate timing reference, a sampled copy of an asynchronous pulse input, and a stream of 30-bit data words. Each frame is started by a one-cycle trigger strobe, which comes from a local line receiver or from a master frame generator. The frame is five bit slots long, and each slot is held on the line for a fixed number of clock cycles. The first two slots are a fixed low/high header. Its rising edge is the timing mark a downstream receiver locks onto.

A frame carries at most one payload bit. Words arrive through a valid/ready word port. They are sent most significant bit first, and each payload bit is flagged valid. After the last bit of a word, the block sends a fixed number of gap frames whose valid and data slots are both low. In those frames the header edge is the only rising edge, so a receiver can realign to word boundaries by dropping partial words. When no word is waiting, every frame is a gap frame. A trigger that arrives during a frame is dropped, and a sticky flag records the loss.

Top module: `wire_frame_tx`

## Requirements
- R1: After reset, `line_o`, `busy_o` and `trig_lost_o` are 0 and `word_ready_o` is 1.
- R2: A trigger sampled while idle starts a frame on the next cycle. The frame slots in time order are: low, high, pulse sample, valid flag, data bit.
- R3: Each slot lasts CYC_PER_BIT cycles (default 8), so a frame lasts 40 cycles. `busy_o` is high for exactly those cycles, and `line_o` is 0 whenever `busy_o` is 0.
- R4: The pulse slot carries the level of `pulse_i` after a SYNC_STAGES-flop synchroniser (default 2), taken on the clock edge that accepts the trigger. A level held for at least 3 cycles before the trigger is reproduced.
- R5: A word is taken on an edge where `word_valid_i` and `word_ready_o` are both 1. Its payload is bits [31:2] of `word_data_i`, and bits [1:0] are ignored. The payload goes out over the next 30 frames, bit 31 first, each frame with valid = 1.
- R6: After the last payload bit of a word, GAP_FRAMES frames (default 1) with valid = 0 and data = 0 follow before the next word can be accepted. `word_ready_o` is 0 from the edge that takes a word until that gap has been sent.
- R7: A frame started while no payload bit is pending has valid = 0 and data = 0.
- R8: A trigger that arrives while `busy_o` is 1 does not alter the current frame and does not start another one. It sets `trig_lost_o`, which stays 1 until reset.
- R9: If a word is taken on the same edge that accepts a trigger, that frame is a gap frame, and the word's first bit goes out in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_trig_i | input | 1 | One-cycle strobe that requests a frame |
| pulse_i | input | 1 | Asynchronous pulse level to be carried |
| word_valid_i | input | 1 | A word is offered on `word_data_i` |
| word_data_i | input | FIFO_W (32) | Offered word, payload left-justified |
| word_ready_o | output | 1 | The block can take a word this cycle |
| line_o | output | 1 | Multiplexed serial output |
| busy_o | output | 1 | A frame is being sent |
| trig_lost_o | output | 1 | Sticky: a trigger was dropped during a frame |

## Verification
Two functions can land on the same clock edge: taking a word from the word port and accepting a frame trigger. The bench provokes this by raising the trigger and the word strobe together while the block is idle and empty. It then judges the result by decoding the next 32 frames at the line: one gap frame, then the 30 payload bits in order, then the mandatory gap. The second meeting point is a trigger that lands inside a frame, sent partway through a word. The line decode must show that frame and the rest of the word unchanged, and the lost flag must rise.

// File: rtl/wft_pkg.sv
package wft_pkg;

   // Slot order inside one frame; the order is the wire format.
   typedef enum logic [2:0] {
      SLOT_LOW   = 3'd0,
      SLOT_HIGH  = 3'd1,
      SLOT_PULSE = 3'd2,
      SLOT_FLAG  = 3'd3,
      SLOT_DATA  = 3'd4
   } slot_e;

   localparam int unsigned NUM_SLOTS = 5;

   // Content captured for one frame when its trigger is accepted.
   typedef struct packed {
      logic pulse;
      logic flag;
      logic data;
   } frame_load_t;

endpackage

// File: rtl/wft_sync.sv
module wft_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_rest
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/wft_word_feed.sv
module wft_word_feed #(
   parameter int unsigned WORD_W     = 30,
   parameter int unsigned FIFO_W     = 32,
   parameter int unsigned GAP_FRAMES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_valid_i,
   input  logic [FIFO_W-1:0] word_data_i,
   output logic              word_ready_o,
   input  logic              take_i,
   output logic              flag_o,
   output logic              data_o
);

   localparam int unsigned BL_W  = $clog2(WORD_W + 1);
   localparam int unsigned GAP_W = $clog2(GAP_FRAMES + 1);

   logic [WORD_W-1:0] shift_q;
   logic [BL_W-1:0]   left_q;
   logic [GAP_W-1:0]  gap_q;
   logic              pop;

   assign word_ready_o = (left_q == '0) && (gap_q == '0);
   assign pop          = word_valid_i && word_ready_o;
   assign flag_o       = (left_q != '0);
   assign data_o       = flag_o && shift_q[WORD_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q <= '0;
         left_q  <= '0;
         gap_q   <= '0;
      end else begin
         if (take_i) begin
            if (left_q != '0) begin
               shift_q <= shift_q << 1;
               left_q  <= left_q - BL_W'(1);
               if (left_q == BL_W'(1)) gap_q <= GAP_W'(GAP_FRAMES);
            end else if (gap_q != '0) begin
               gap_q <= gap_q - GAP_W'(1);
            end
         end
         if (pop) begin
            shift_q <= word_data_i[FIFO_W-1 -: WORD_W];
            left_q  <= BL_W'(WORD_W);
         end
      end
   end

   AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (left_q == BL_W'(WORD_W)) && !word_ready_o); // R5

   AST_GAP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && left_q == BL_W'(1)) |=> (gap_q == GAP_W'(GAP_FRAMES)) && !word_ready_o); // R6

   AST_COLLIDE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && pop) |-> !flag_o); // R9

endmodule

// File: rtl/wft_frame_seq.sv
module wft_frame_seq
   import wft_pkg::*;
#(
   parameter int unsigned CYC_PER_BIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic pulse_s_i,
   input  logic flag_i,
   input  logic data_i,
   output logic take_o,
   output logic busy_o,
   output logic line_o,
   output logic trig_lost_o
);

   localparam int unsigned CNT_W = $clog2(CYC_PER_BIT);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CYC_PER_BIT - 1);

   slot_e            slot_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             lost_q;
   frame_load_t      load_q;
   logic             slot_end;
   logic             frame_end;

   assign take_o    = trig_i && !busy_q;
   assign slot_end  = busy_q && (cnt_q == CNT_MAX);
   assign frame_end = slot_end && (slot_q == SLOT_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         slot_q <= SLOT_LOW;
         cnt_q  <= '0;
         load_q <= '0;
      end else if (take_o) begin
         busy_q <= 1'b1;
         slot_q <= SLOT_LOW;
         cnt_q  <= '0;
         load_q <= '{pulse: pulse_s_i, flag: flag_i, data: data_i};
      end else if (busy_q) begin
         if (slot_end) begin
            cnt_q <= '0;
            if (frame_end) begin
               busy_q <= 1'b0;
               slot_q <= SLOT_LOW;
            end else begin
               slot_q <= slot_e'(slot_q + 3'd1);
            end
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                lost_q <= 1'b0;
      else if (trig_i && busy_q) lost_q <= 1'b1;
   end

   always_comb begin
      line_o = 1'b0;
      if (busy_q) begin
         unique case (slot_q)
            SLOT_LOW:   line_o = 1'b0;
            SLOT_HIGH:  line_o = 1'b1;
            SLOT_PULSE: line_o = load_q.pulse;
            SLOT_FLAG:  line_o = load_q.flag;
            SLOT_DATA:  line_o = load_q.data;
            default:    line_o = 1'b0;
         endcase
      end
   end

   assign busy_o      = busy_q;
   assign trig_lost_o = lost_q;

   AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !line_o); // R2

   AST_HEADER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && slot_q == SLOT_LOW) |=> line_o && busy_o); // R2

   AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !frame_end) |=> busy_q && $stable(load_q)); // R8

   AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      trig_lost_o |=> trig_lost_o); // R8

   AST_GAP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !load_q.flag) |-> !load_q.data); // R7

endmodule

// File: rtl/wire_frame_tx.sv
module wire_frame_tx #(
   parameter int unsigned WORD_W      = 30,
   parameter int unsigned FIFO_W      = 32,
   parameter int unsigned CYC_PER_BIT = 8,
   parameter int unsigned GAP_FRAMES  = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_trig_i,
   input  logic              pulse_i,
   input  logic              word_valid_i,
   input  logic [FIFO_W-1:0] word_data_i,
   output logic              word_ready_o,
   output logic              line_o,
   output logic              busy_o,
   output logic              trig_lost_o
);

   generate
      if (WORD_W < 1 || WORD_W > FIFO_W) begin : g_bad_word
         $error("wire_frame_tx: WORD_W must lie in 1..FIFO_W");
      end
      if (CYC_PER_BIT < 2) begin : g_bad_cyc
         $error("wire_frame_tx: CYC_PER_BIT must be at least 2");
      end
      if (GAP_FRAMES < 1) begin : g_bad_gap
         $error("wire_frame_tx: GAP_FRAMES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wire_frame_tx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic pulse_s;
   logic take;
   logic flag;
   logic data;

   wft_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pulse_i),
      .q_o   (pulse_s)
   );

   wft_word_feed #(
      .WORD_W     (WORD_W),
      .FIFO_W     (FIFO_W),
      .GAP_FRAMES (GAP_FRAMES)
   ) u_feed (
      .clk          (clk),
      .rst_n        (rst_n),
      .word_valid_i (word_valid_i),
      .word_data_i  (word_data_i),
      .word_ready_o (word_ready_o),
      .take_i       (take),
      .flag_o       (flag),
      .data_o       (data)
   );

   wft_frame_seq #(.CYC_PER_BIT(CYC_PER_BIT)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (frame_trig_i),
      .pulse_s_i   (pulse_s),
      .flag_i      (flag),
      .data_i      (data),
      .take_o      (take),
      .busy_o      (busy_o),
      .line_o      (line_o),
      .trig_lost_o (trig_lost_o)
   );

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !line_o); // R3

endmodule

// File: tb/wire_frame_tx_tb.sv
module wire_frame_tx_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_trig_i = 1'b0;
   logic        pulse_i = 1'b0;
   logic        word_valid_i = 1'b0;
   logic [31:0] word_data_i = '0;
   logic        word_ready_o;
   logic        line_o;
   logic        busy_o;
   logic        trig_lost_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wire_frame_tx dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_trig_i (frame_trig_i),
      .pulse_i      (pulse_i),
      .word_valid_i (word_valid_i),
      .word_data_i  (word_data_i),
      .word_ready_o (word_ready_o),
      .line_o       (line_o),
      .busy_o       (busy_o),
      .trig_lost_o  (trig_lost_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Drives one frame and decodes it at the middle of each slot.
   task automatic run_frame(input bit p, input bit v, input bit d,
                            input bit inject, input bit collide,
                            input logic [31:0] cw);
      bit exp_slot [5];
      exp_slot[0] = 1'b0; exp_slot[1] = 1'b1; exp_slot[2] = p;
      exp_slot[3] = v;    exp_slot[4] = d;
      pulse_i = p;
      repeat (3) @(negedge clk);
      frame_trig_i = 1'b1;
      if (collide) begin
         word_valid_i = 1'b1;
         word_data_i  = cw;
      end
      @(negedge clk);
      frame_trig_i = 1'b0;
      word_valid_i = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy_o === 1'b1, "R3 busy in frame", busy_o, 1);
      for (int k = 0; k < 5; k++) begin
         if (k > 0) repeat ((inject && k == 2) ? 7 : 8) @(negedge clk);
         chk(line_o === exp_slot[k],
             (k == 2) ? "R4 pulse slot" : (k == 3) ? "R5/R7 flag slot" :
             (k == 4) ? "R5/R7 data slot" : "R2 header slot",
             line_o, exp_slot[k]);
         if (inject && k == 1) begin
            frame_trig_i = 1'b1;
            @(negedge clk);
            frame_trig_i = 1'b0;
         end
      end
      repeat (4) @(negedge clk);
      chk(busy_o === 1'b1 && line_o === d, "R3 last cycle of frame", busy_o, 1);
      @(negedge clk);
      chk(busy_o === 1'b0 && line_o === 1'b0, "R3 frame ends after 40 cycles", busy_o, 0);
      if (inject) begin
         repeat (3) @(negedge clk);
         chk(busy_o === 1'b0, "R8 dropped trigger starts no frame", busy_o, 0);
         chk(trig_lost_o === 1'b1, "R8 lost flag set", trig_lost_o, 1);
      end
   endtask

   task automatic offer_word(input logic [31:0] w);
      chk(word_ready_o === 1'b1, "R6 ready before load", word_ready_o, 1);
      word_valid_i = 1'b1;
      word_data_i  = w;
      @(negedge clk);
      word_valid_i = 1'b0;
      word_data_i  = 32'hFFFF_FFFF;
      chk(word_ready_o === 1'b0, "R6 ready drops on load", word_ready_o, 0);
   endtask

   function automatic logic [29:0] payload(input int idx);
      case (idx)
         0: payload = 30'h2AAA_AAAA;
         1: payload = 30'h0000_0001;
         2: payload = 30'h2000_0000;
         default: payload = 30'h1234_5678;
      endcase
   endfunction

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(line_o === 1'b0, "R1 line after reset", line_o, 0);
      chk(busy_o === 1'b0, "R1 busy after reset", busy_o, 0);
      chk(trig_lost_o === 1'b0, "R1 lost flag after reset", trig_lost_o, 0);
      chk(word_ready_o === 1'b1, "R1 ready after reset", word_ready_o, 1);

      // R5 R6: three words back to back, low bits of the entry set to 1s.
      for (int w = 0; w < 3; w++) begin
         for (int pos = 0; pos <= 30; pos++) begin
            logic [29:0] pl;
            bit pv;
            pl = payload(w);
            pv = ((w * 31 + pos) % 3) == 1;
            if (pos == 0) offer_word({pl, 2'b11});
            else chk(word_ready_o === 1'b0, "R6 ready low during word and gap",
                     word_ready_o, 0);
            if (pos < 30)
               run_frame(pv, 1'b1, pl[29-pos], (w == 1 && pos == 5), 1'b0, '0);
            else
               run_frame(pv, 1'b0, 1'b0, 1'b0, 1'b0, '0);
         end
      end

      // R7: no word pending.
      for (int f = 0; f < 3; f++) begin
         chk(word_ready_o === 1'b1, "R7 ready while empty", word_ready_o, 1);
         run_frame(f[0], 1'b0, 1'b0, 1'b0, 1'b0, '0);
      end

      // R9: word taken on the trigger edge.
      run_frame(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, {payload(3), 2'b01});
      for (int pos = 0; pos < 30; pos++) begin
         logic [29:0] pl;
         pl = payload(3);
         chk(word_ready_o === 1'b0, "R9 word held after collision", word_ready_o, 0);
         run_frame(pos[1], 1'b1, pl[29-pos], 1'b0, 1'b0, '0);
      end
      run_frame(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      chk(word_ready_o === 1'b1, "R6 ready after gap", word_ready_o, 1);
      chk(trig_lost_o === 1'b1, "R8 lost flag still set", trig_lost_o, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule